// File: doc/BRIEF.md
# Branch and State-Exchange Unit

This block computes the program counter that follows a control-transfer instruction in a 32-bit core that can run in two instruction-set states: a full-width state and a compact state. A decoder supplies the condition outcome, a two-bit transfer kind, a link request, a 24-bit signed word offset and a register operand, together with the PC of the instruction. The register file and the exception vector logic live elsewhere.

For each input strobe the block produces, one cycle later, the next PC, an optional write of a return address to register 14, the current instruction-set state bit, a one-bit pipeline action (step or flush) and a single-cycle software-interrupt request. The state bit is held inside the block. Only a register-indirect transfer changes it, by taking the bit 0 of its operand. The sequential step size follows the state: 4 bytes in full-width state and 2 bytes in compact state.

Top module: `branch_xchg_unit`

## Requirements
- R1: During and right after synchronous reset, `out_valid`, `lr_we` and `swi_req` are 0, `compact` is 0 and `action` is 0 (step).
- R2: A strobe with `cond_pass`=0 has no effect, whatever its kind or link flag. The result is `action`=0, `lr_we`=0, `swi_req`=0, `compact` unchanged and `next_pc` set to the sequential address.
- R3: A passing direct transfer (`kind`=1) gives `next_pc` = `cur_pc` + (offset sign-extended, shifted left by 2), wrapping modulo 2^32, with `action`=1 (flush).
- R4: A passing direct transfer with `link`=1 sets `lr_we`=1, `lr_idx`=14 and `lr_data` = `cur_pc` with bit 0 cleared. `link` has no effect on any other kind.
- R5: A passing register-indirect transfer (`kind`=2) gives `next_pc` = `opnd` with bit 0 cleared and `action`=1.
- R6: A passing register-indirect transfer sets `compact` to `opnd[0]`. No other strobe changes `compact`.
- R7: A passing software interrupt (`kind`=3) raises `swi_req` for exactly one cycle, with `action`=1 and `next_pc` = `cur_pc`.
- R8: A passing strobe with `kind`=0 (no transfer) gives `action`=0 and the sequential address.
- R9: All outputs are registered. `out_valid` is 1 exactly in the cycle after an `in_valid` strobe, and `lr_we` and `swi_req` are 0 whenever `out_valid` is 0.
- R10: The sequential address is `cur_pc`+4 while `compact` is 0 and `cur_pc`+2 while `compact` is 1, taken from the state before the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction strobe |
| cond_pass | input | 1 | Condition check outcome |
| kind | input | 2 | 0 none, 1 direct, 2 register-indirect, 3 software interrupt |
| link | input | 1 | Request return-address write |
| offset | input | 24 | Signed word offset for direct transfers |
| opnd | input | 32 | Register operand for indirect transfers |
| cur_pc | input | 32 | PC value of the instruction |
| out_valid | output | 1 | Result valid |
| next_pc | output | 32 | Computed next PC |
| lr_we | output | 1 | Return-address write enable |
| lr_idx | output | 4 | Destination register index (14) |
| lr_data | output | 32 | Return address |
| compact | output | 1 | Instruction-set state, 1 = compact |
| action | output | 1 | 0 step, 1 flush |
| swi_req | output | 1 | Software-interrupt request |

## Verification
The assertions assume a synchronous, glitch-free `in_valid`. They also assume that `kind`, `link`, `offset`, `opnd` and `cur_pc` are meaningful only in a strobe cycle, so every relation between inputs and outputs is gated on `in_valid` in the previous cycle. The stimulus drives all inputs on the falling edge and keeps `in_valid` high for exactly one cycle per instruction. Between strobes it leaves a quiet cycle, so the single-cycle software-interrupt pulse and the hold of the state bit can be observed at the ports.

// File: rtl/bxu_pkg.sv
package bxu_pkg;
  localparam int KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    XK_SEQ      = 2'd0,
    XK_DIRECT   = 2'd1,
    XK_INDIRECT = 2'd2,
    XK_SWI      = 2'd3
  } xfer_kind_e;

  typedef enum logic {
    ACT_STEP  = 1'b0,
    ACT_FLUSH = 1'b1
  } pipe_act_e;
endpackage

// File: rtl/bxu_target.sv
// Address arithmetic: direct target, indirect target, sequential step, link value.
module bxu_target #(
  parameter int XLEN       = 32,
  parameter int OFS_W      = 24,
  parameter int SHIFT      = 2,
  parameter int INC_WIDE   = 4,
  parameter int INC_NARROW = 2
) (
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [OFS_W-1:0] offset,
  input  logic [XLEN-1:0]  opnd,
  input  logic             compact,
  output logic [XLEN-1:0]  br_tgt,
  output logic [XLEN-1:0]  ind_tgt,
  output logic [XLEN-1:0]  seq_pc,
  output logic [XLEN-1:0]  link_val
);
  localparam int EXT_W = XLEN - OFS_W - SHIFT;

  logic [XLEN-1:0] ofs_ext;

  generate
    if (SHIFT > 0) begin : g_shift
      assign ofs_ext = {{EXT_W{offset[OFS_W-1]}}, offset, {SHIFT{1'b0}}};
    end else begin : g_noshift
      assign ofs_ext = {{EXT_W{offset[OFS_W-1]}}, offset};
    end
  endgenerate

  assign br_tgt   = cur_pc + ofs_ext;
  assign ind_tgt  = {opnd[XLEN-1:1], 1'b0};
  assign link_val = {cur_pc[XLEN-1:1], 1'b0};
  assign seq_pc   = cur_pc + (compact ? XLEN'(INC_NARROW) : XLEN'(INC_WIDE));
endmodule

// File: rtl/bxu_select.sv
// Per-kind decision: picks the next PC and side effects for one instruction.
module bxu_select
  import bxu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              cond_pass,
  input  logic [KIND_W-1:0] kind,
  input  logic              link,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   br_tgt,
  input  logic [XLEN-1:0]   ind_tgt,
  input  logic [XLEN-1:0]   seq_pc,
  output logic [XLEN-1:0]   sel_pc,
  output logic              sel_flush,
  output logic              sel_lr_we,
  output logic              sel_swi,
  output logic              sel_st_load
);
  xfer_kind_e k;
  assign k = xfer_kind_e'(kind);

  always_comb begin
    sel_pc      = seq_pc;
    sel_flush   = ACT_STEP;
    sel_lr_we   = 1'b0;
    sel_swi     = 1'b0;
    sel_st_load = 1'b0;
    if (cond_pass) begin
      unique case (k)
        XK_DIRECT: begin
          sel_pc    = br_tgt;
          sel_flush = ACT_FLUSH;
          sel_lr_we = link;
        end
        XK_INDIRECT: begin
          sel_pc      = ind_tgt;
          sel_flush   = ACT_FLUSH;
          sel_st_load = 1'b1;
        end
        XK_SWI: begin
          sel_pc    = cur_pc;
          sel_flush = ACT_FLUSH;
          sel_swi   = 1'b1;
        end
        default: begin
          sel_pc = seq_pc;
        end
      endcase
    end
  end
endmodule

// File: rtl/bxu_state.sv
// Instruction-set state register.
module bxu_state (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic new_bit,
  output logic state_q
);
  always_ff @(posedge clk) begin
    if (rst)       state_q <= 1'b0;
    else if (load) state_q <= new_bit;
  end
endmodule

// File: rtl/bxu_outreg.sv
// Output register stage.
module bxu_outreg #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [XLEN-1:0] d_pc,
  input  logic            d_flush,
  input  logic            d_lr_we,
  input  logic [XLEN-1:0] d_lr_data,
  input  logic            d_swi,
  output logic            q_valid,
  output logic [XLEN-1:0] q_pc,
  output logic            q_flush,
  output logic            q_lr_we,
  output logic [XLEN-1:0] q_lr_data,
  output logic            q_swi
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid   <= 1'b0;
      q_pc      <= '0;
      q_flush   <= 1'b0;
      q_lr_we   <= 1'b0;
      q_lr_data <= '0;
      q_swi     <= 1'b0;
    end else begin
      q_valid <= in_valid;
      q_lr_we <= in_valid & d_lr_we;
      q_swi   <= in_valid & d_swi;
      if (in_valid) begin
        q_pc      <= d_pc;
        q_flush   <= d_flush;
        q_lr_data <= d_lr_data;
      end
    end
  end
endmodule

// File: rtl/branch_xchg_unit.sv
module branch_xchg_unit
  import bxu_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int OFS_W      = 24,
  parameter int SHIFT      = 2,
  parameter int INC_WIDE   = 4,
  parameter int INC_NARROW = 2,
  parameter int RIDX_W     = 4,
  parameter int LINK_IDX   = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              cond_pass,
  input  logic [1:0]        kind,
  input  logic              link,
  input  logic [OFS_W-1:0]  offset,
  input  logic [XLEN-1:0]   opnd,
  input  logic [XLEN-1:0]   cur_pc,
  output logic              out_valid,
  output logic [XLEN-1:0]   next_pc,
  output logic              lr_we,
  output logic [RIDX_W-1:0] lr_idx,
  output logic [XLEN-1:0]   lr_data,
  output logic              compact,
  output logic              action,
  output logic              swi_req
);
  logic [XLEN-1:0] br_tgt, ind_tgt, seq_pc, link_val, sel_pc;
  logic            sel_flush, sel_lr_we, sel_swi, sel_st_load;

  bxu_target #(
    .XLEN(XLEN), .OFS_W(OFS_W), .SHIFT(SHIFT),
    .INC_WIDE(INC_WIDE), .INC_NARROW(INC_NARROW)
  ) u_tgt (
    .cur_pc(cur_pc), .offset(offset), .opnd(opnd), .compact(compact),
    .br_tgt(br_tgt), .ind_tgt(ind_tgt), .seq_pc(seq_pc), .link_val(link_val)
  );

  bxu_select #(.XLEN(XLEN)) u_sel (
    .cond_pass(cond_pass), .kind(kind), .link(link), .cur_pc(cur_pc),
    .br_tgt(br_tgt), .ind_tgt(ind_tgt), .seq_pc(seq_pc),
    .sel_pc(sel_pc), .sel_flush(sel_flush), .sel_lr_we(sel_lr_we),
    .sel_swi(sel_swi), .sel_st_load(sel_st_load)
  );

  bxu_state u_st (
    .clk(clk), .rst(rst), .load(in_valid & sel_st_load),
    .new_bit(opnd[0]), .state_q(compact)
  );

  bxu_outreg #(.XLEN(XLEN)) u_out (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .d_pc(sel_pc), .d_flush(sel_flush), .d_lr_we(sel_lr_we),
    .d_lr_data(link_val), .d_swi(sel_swi),
    .q_valid(out_valid), .q_pc(next_pc), .q_flush(action),
    .q_lr_we(lr_we), .q_lr_data(lr_data), .q_swi(swi_req)
  );

  assign lr_idx = RIDX_W'(LINK_IDX);
endmodule

// File: rtl/bxu_checker.sv
module bxu_checker #(
  parameter int XLEN     = 32,
  parameter int OFS_W    = 24,
  parameter int SHIFT    = 2,
  parameter int RIDX_W   = 4,
  parameter int LINK_IDX = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              cond_pass,
  input logic [1:0]        kind,
  input logic              link,
  input logic [OFS_W-1:0]  offset,
  input logic [XLEN-1:0]   opnd,
  input logic [XLEN-1:0]   cur_pc,
  input logic              out_valid,
  input logic [XLEN-1:0]   next_pc,
  input logic              lr_we,
  input logic [RIDX_W-1:0] lr_idx,
  input logic [XLEN-1:0]   lr_data,
  input logic              compact,
  input logic              action,
  input logic              swi_req
);
  localparam int EXT_W = XLEN - OFS_W - SHIFT;

  logic [XLEN-1:0] ref_direct;
  logic            go_dir, go_ind, go_swi;
  assign ref_direct = cur_pc + {{EXT_W{offset[OFS_W-1]}}, offset, {SHIFT{1'b0}}};
  assign go_dir = in_valid && cond_pass && kind == 2'd1;
  assign go_ind = in_valid && cond_pass && kind == 2'd2;
  assign go_swi = in_valid && cond_pass && kind == 2'd3;

  p_valid_follows_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !lr_we && !swi_req));
  p_fail_noeffect_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cond_pass) |=> (!action && !lr_we && !swi_req && $stable(compact)));
  p_direct_target_r3: assert property (@(posedge clk) disable iff (rst)
    go_dir |=> (next_pc == $past(ref_direct) && action));
  p_link_value_r4: assert property (@(posedge clk) disable iff (rst)
    (go_dir && link) |=> (lr_we && lr_idx == RIDX_W'(LINK_IDX) && lr_data == {$past(cur_pc[XLEN-1:1]), 1'b0}));
  p_link_other_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !(go_dir && link)) |=> !lr_we);
  p_indirect_r5: assert property (@(posedge clk) disable iff (rst)
    go_ind |=> (next_pc == {$past(opnd[XLEN-1:1]), 1'b0} && action));
  p_state_take_r6: assert property (@(posedge clk) disable iff (rst)
    go_ind |=> (compact == $past(opnd[0])));
  p_state_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !go_ind |=> $stable(compact));
  p_swi_flush_r7: assert property (@(posedge clk) disable iff (rst)
    go_swi |=> (swi_req && action && next_pc == $past(cur_pc)));
  p_swi_only_r7: assert property (@(posedge clk) disable iff (rst)
    !go_swi |=> !swi_req);
endmodule

bind branch_xchg_unit bxu_checker #(
  .XLEN(XLEN), .OFS_W(OFS_W), .SHIFT(SHIFT), .RIDX_W(RIDX_W), .LINK_IDX(LINK_IDX)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .cond_pass(cond_pass),
  .kind(kind), .link(link), .offset(offset), .opnd(opnd), .cur_pc(cur_pc),
  .out_valid(out_valid), .next_pc(next_pc), .lr_we(lr_we), .lr_idx(lr_idx),
  .lr_data(lr_data), .compact(compact), .action(action), .swi_req(swi_req)
);

// File: tb/sim_branch_xchg_unit.sv
`timescale 1ns/1ps
module sim_branch_xchg_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, cond_pass = 1'b0, link = 1'b0;
  logic [1:0]  kind = 2'd0;
  logic [23:0] offset = '0;
  logic [31:0] opnd = '0, cur_pc = '0;
  logic        out_valid, lr_we, compact, action, swi_req;
  logic [31:0] next_pc, lr_data;
  logic [3:0]  lr_idx;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  branch_xchg_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cond_pass(cond_pass),
    .kind(kind), .link(link), .offset(offset), .opnd(opnd), .cur_pc(cur_pc),
    .out_valid(out_valid), .next_pc(next_pc), .lr_we(lr_we), .lr_idx(lr_idx),
    .lr_data(lr_data), .compact(compact), .action(action), .swi_req(swi_req)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] dir_ref(input logic [31:0] pc, input logic [23:0] o);
    return pc + {{6{o[23]}}, o, 2'b00};
  endfunction

  // one strobe; returns with outputs of that strobe visible
  task automatic issue(input logic c, input logic [1:0] k, input logic l,
                       input logic [23:0] o, input logic [31:0] r, input logic [31:0] pc);
    @(negedge clk);
    in_valid = 1'b1; cond_pass = c; kind = k; link = l;
    offset = o; opnd = r; cur_pc = pc;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "out_valid", 32'(out_valid), 32'd0);
    chk("R1", "lr_we", 32'(lr_we), 32'd0);
    chk("R1", "swi_req", 32'(swi_req), 32'd0);
    chk("R1", "compact", 32'(compact), 32'd0);
    chk("R1", "action", 32'(action), 32'd0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk("R9", "idle out_valid", 32'(out_valid), 32'd0);
  endtask

  task automatic t_cond_fail;
    issue(1'b0, 2'd1, 1'b1, 24'h000100, 32'h0, 32'h0000_1000);
    chk("R9", "valid", 32'(out_valid), 32'd1);
    chk("R2", "action", 32'(action), 32'd0);
    chk("R2", "lr_we", 32'(lr_we), 32'd0);
    chk("R2", "next_pc", next_pc, 32'h0000_1004);
    issue(1'b0, 2'd2, 1'b0, 24'h0, 32'h0000_0777, 32'h0000_1100);
    chk("R2", "compact held", 32'(compact), 32'd0);
    chk("R2", "fail indirect next_pc", next_pc, 32'h0000_1104);
    issue(1'b0, 2'd3, 1'b0, 24'h0, 32'h0, 32'h0000_1200);
    chk("R2", "fail swi", 32'(swi_req), 32'd0);
  endtask

  task automatic t_direct;
    issue(1'b1, 2'd1, 1'b0, 24'h000010, 32'h0, 32'h0000_2000);
    chk("R3", "fwd", next_pc, dir_ref(32'h0000_2000, 24'h000010));
    chk("R3", "flush", 32'(action), 32'd1);
    chk("R4", "no link", 32'(lr_we), 32'd0);
    issue(1'b1, 2'd1, 1'b0, 24'h000008, 32'h0, 32'hFFFF_FFF0);
    chk("R3", "wrap", next_pc, 32'h0000_0010);
    issue(1'b1, 2'd1, 1'b0, 24'h800000, 32'h0, 32'h0000_0000);
    chk("R3", "most negative", next_pc, 32'hFE00_0000);
  endtask

  task automatic t_link;
    issue(1'b1, 2'd1, 1'b1, 24'hFFFFFF, 32'h0, 32'h0000_3001);
    chk("R3", "back", next_pc, 32'h0000_2FFD);
    chk("R4", "lr_we", 32'(lr_we), 32'd1);
    chk("R4", "lr_idx", 32'(lr_idx), 32'd14);
    chk("R4", "lr_data", lr_data, 32'h0000_3000);
  endtask

  task automatic t_indirect_compact;
    issue(1'b1, 2'd2, 1'b1, 24'h0, 32'h0000_8001, 32'h0000_0400);
    chk("R5", "target", next_pc, 32'h0000_8000);
    chk("R5", "flush", 32'(action), 32'd1);
    chk("R6", "compact set", 32'(compact), 32'd1);
    chk("R4", "link ignored", 32'(lr_we), 32'd0);
  endtask

  task automatic t_seq_compact;
    issue(1'b1, 2'd0, 1'b1, 24'h000040, 32'h0000_0003, 32'h0000_8000);
    chk("R8", "action", 32'(action), 32'd0);
    chk("R10", "step 2", next_pc, 32'h0000_8002);
    chk("R6", "compact kept", 32'(compact), 32'd1);
    chk("R4", "link on seq", 32'(lr_we), 32'd0);
  endtask

  task automatic t_swi;
    issue(1'b1, 2'd3, 1'b0, 24'h000040, 32'h0, 32'h0000_0500);
    chk("R7", "swi", 32'(swi_req), 32'd1);
    chk("R7", "flush", 32'(action), 32'd1);
    chk("R7", "next_pc", next_pc, 32'h0000_0500);
    chk("R6", "compact kept", 32'(compact), 32'd1);
    @(negedge clk);
    chk("R7", "single pulse", 32'(swi_req), 32'd0);
    chk("R9", "valid dropped", 32'(out_valid), 32'd0);
  endtask

  task automatic t_back_to_full;
    issue(1'b1, 2'd2, 1'b0, 24'h0, 32'h0000_4000, 32'h0000_8010);
    chk("R6", "compact clear", 32'(compact), 32'd0);
    chk("R5", "target", next_pc, 32'h0000_4000);
    issue(1'b1, 2'd0, 1'b0, 24'h0, 32'h0, 32'h0000_4000);
    chk("R10", "step 4", next_pc, 32'h0000_4004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_idle();
    t_reset();
    t_cond_fail();
    t_direct();
    t_link();
    t_indirect_compact();
    t_seq_compact();
    t_swi();
    t_back_to_full();
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule